// File: doc/BRIEF.md
# Lane-Checked SRAM Write Path with Read-Merge-Write

This block is the write side of a wide SRAM controller. A memory word is 256 bits, handled as eight independent 32-bit lanes. Each lane has its own 7-bit single-error-correct, double-error-detect check code, so a stored word carries 56 check bits. A client hands over one write request at a time: an address, 256 bits of data and one enable bit per byte.

When every lane in the request is either written in full or left untouched, the block encodes the new data and issues a single memory write with a per-lane write mask. When any lane is written only in part, the check code cannot be formed from the request alone. The block then reads the stored word once and overlays the enabled bytes on it. It re-encodes every lane from the merged word and writes the whole word back. The memory side is a plain synchronous port whose read latency is a parameter.

Top module: `ecc_sram_wr`

## Requirements
- R1: The check code of lane i, driven on `mem_wr_chk[7i+6:7i]` for data `mem_wr_data[32i+31:32i]`, is formed as follows. Data bit k sits at the k-th codeword position, counting from 1, that is not a power of two (3, 5, 6, 7, 9, ...). Check bit j, for j from 0 to 5, is the XOR of the data bits whose position has bit j set. Check bit 6 is the XOR of all 32 data bits and check bits 0 to 5.
- R2: After reset, `req_ready` is 1 and `mem_rd_req` and `mem_wr_en` are 0. `req_ready` is 1 only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: A request with no partial lane issues no read. Each lane's four enables, where enable bit b of a lane covers lane bits [8b+7:8b], must be 0000 or 1111. `mem_wr_en` is 1 in exactly the cycle after acceptance, with the request's data and address. `req_ready` is 1 again in the cycle after that.
- R4: A lane is partial when some, but not all four, of its enables are set. A request with at least one partial lane issues exactly one `mem_rd_req` pulse, with the request address, in the cycle after acceptance. There is no write before the read data returns, however many lanes are partial.
- R5: Read data is taken RD_LAT cycles after the read-request cycle. For a request with a partial lane, the write cycle is cycle RD_LAT+2 after acceptance.
- R6: In a read-merge-write, each byte with its enable set comes from the request and every other byte comes from the read data. The codes are computed over the merged word.
- R7: On the direct path, `mem_wr_lane_mask[i]` is 1 exactly when lane i has any enable set. On the read-merge-write path, the mask is all ones, and lanes with no enables are rewritten with their stored data and a fresh code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | 256 | Write data, eight 32-bit lanes |
| req_be | input | 32 | Byte enables, bit n covers data bits [8n+7:8n] |
| mem_rd_req | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 256 | Memory read data, RD_LAT cycles after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 256 | Memory write data |
| mem_wr_chk | output | 56 | Check codes, 7 bits per lane |
| mem_wr_lane_mask | output | 8 | Per-lane write mask |

## Verification
A walking single one in each lane, under full enables, isolates every column of the check-code matrix. Wrong wiring of any one data bit into the code therefore shows up on its own. Every 16-value enable nibble is swept on the lowest and the highest lane, with all other lanes full. This separates the direct path from the read path at the exact boundary between "all" and "some" enables, and shows each byte position being taken from the right source. Pseudo-random mixes of empty, full and partial lanes then exercise the mask, the single shared read and the latency of both paths together. The all-clear enable pattern is also included.

// File: rtl/ecc_wr_pkg.sv
package ecc_wr_pkg;
  localparam int LANE_W  = 32;
  localparam int CHK_W   = 7;
  localparam int LANE_BE = LANE_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_MERGE_ENCODE,
    ST_WRITE
  } wr_state_e;

  // Hamming code over 32 data bits with an added overall parity bit.
  function automatic logic [CHK_W-1:0] ecc_encode32(input logic [LANE_W-1:0] d);
    logic [CHK_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < 40; p++) begin
      if (((p & (p - 1)) != 0) && (k < LANE_W)) begin
        if (d[k]) begin
          for (int j = 0; j < CHK_W - 1; j++) begin
            if (((p >> j) & 1) == 1) c[j] = ~c[j];
          end
        end
        k++;
      end
    end
    c[CHK_W-1] = (^d) ^ (^c[CHK_W-2:0]);
    return c;
  endfunction

  function automatic logic lane_is_partial(input logic [LANE_BE-1:0] be);
    return (|be) && !(&be);
  endfunction
endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
  import ecc_wr_pkg::*;
(
  input  logic [LANE_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  always_comb chk = ecc_encode32(data);
endmodule

// File: rtl/ecc_wr_merge.sv
module ecc_wr_merge
  import ecc_wr_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * LANE_W,
  localparam int BW = DW / 8
) (
  input  logic [DW-1:0] new_data,
  input  logic [BW-1:0] new_be,
  input  logic [DW-1:0] old_data,
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign merged[8*b +: 8] = new_be[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
endmodule

// File: rtl/ecc_wr_ctrl.sv
module ecc_wr_ctrl
  import ecc_wr_pkg::*;
#(
  parameter int RD_LAT = 1,
  localparam int CW = $clog2(RD_LAT + 1) + 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      need_rmw,
  output logic      req_ready,
  output logic      accept,
  output logic      ld_direct,
  output logic      ld_merge,
  output logic      rd_req,
  output logic      wr_en,
  output wr_state_e state
);
  wr_state_e      state_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           lat_done;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign ld_direct = accept && !need_rmw;
  assign ld_merge  = (state == ST_MERGE_ENCODE);
  assign rd_req    = (state == ST_READ_REQ);
  assign wr_en     = (state == ST_WRITE);

  always_comb begin
    state_n  = state;
    cnt_n    = cnt_q;
    lat_done = 1'b0;
    case (state)
      ST_IDLE: if (accept) state_n = need_rmw ? ST_READ_REQ : ST_WRITE;
      ST_READ_REQ: begin
        cnt_n    = CW'(1);
        lat_done = (RD_LAT == 1);
        state_n  = lat_done ? ST_MERGE_ENCODE : ST_READ_WAIT;
      end
      ST_READ_WAIT: begin
        cnt_n    = cnt_q + CW'(1);
        lat_done = (cnt_n == CW'(RD_LAT));
        if (lat_done) state_n = ST_MERGE_ENCODE;
      end
      ST_MERGE_ENCODE: state_n = ST_WRITE;
      ST_WRITE:        state_n = ST_IDLE;
      default:         state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/ecc_sram_wr.sv
module ecc_sram_wr
  import ecc_wr_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 16,
  parameter int RD_LAT = 1,
  localparam int DW = LANES * LANE_W,
  localparam int BW = DW / 8,
  localparam int CK = LANES * CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [BW-1:0]     req_be,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  output logic [CK-1:0]     mem_wr_chk,
  output logic [LANES-1:0]  mem_wr_lane_mask
);
  // named internal events, also used by the checker
  logic             accept, ld_direct, ld_merge, need_rmw;
  logic [LANES-1:0] lane_partial, lane_any;
  wr_state_e        state;

  logic [DW-1:0]     hold_data, merged, enc_in;
  logic [BW-1:0]     hold_be;
  logic [ADDR_W-1:0] hold_addr;
  logic [CK-1:0]     enc_out;
  logic [DW-1:0]     wr_data_q;
  logic [CK-1:0]     wr_chk_q;
  logic [LANES-1:0]  wr_mask_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_cls
    assign lane_partial[i] = lane_is_partial(req_be[LANE_BE*i +: LANE_BE]);
    assign lane_any[i]     = |req_be[LANE_BE*i +: LANE_BE];
  end
  assign need_rmw = |lane_partial;

  ecc_wr_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .need_rmw  (need_rmw),
    .req_ready (req_ready),
    .accept    (accept),
    .ld_direct (ld_direct),
    .ld_merge  (ld_merge),
    .rd_req    (mem_rd_req),
    .wr_en     (mem_wr_en),
    .state     (state)
  );

  ecc_wr_merge #(.LANES(LANES)) u_merge (
    .new_data (hold_data),
    .new_be   (hold_be),
    .old_data (mem_rd_data),
    .merged   (merged)
  );

  assign enc_in = ld_merge ? merged : req_data;

  for (genvar i = 0; i < LANES; i++) begin : g_enc
    ecc_lane_enc u_enc (
      .data (enc_in[LANE_W*i +: LANE_W]),
      .chk  (enc_out[CHK_W*i +: CHK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_be   <= '0;
      hold_addr <= '0;
      wr_data_q <= '0;
      wr_chk_q  <= '0;
      wr_mask_q <= '0;
    end else begin
      if (accept) begin
        hold_data <= req_data;
        hold_be   <= req_be;
        hold_addr <= req_addr;
      end
      if (ld_direct) begin
        wr_data_q <= req_data;
        wr_chk_q  <= enc_out;
        wr_mask_q <= lane_any;
      end else if (ld_merge) begin
        wr_data_q <= merged;
        wr_chk_q  <= enc_out;
        wr_mask_q <= '1;
      end
    end
  end

  assign mem_rd_addr      = hold_addr;
  assign mem_wr_addr      = hold_addr;
  assign mem_wr_data      = wr_data_q;
  assign mem_wr_chk       = wr_chk_q;
  assign mem_wr_lane_mask = wr_mask_q;
endmodule

// File: rtl/ecc_sram_wr_chk.sv
module ecc_sram_wr_chk
  import ecc_wr_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * LANE_W,
  localparam int CK = LANES * CHK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             accept,
  input logic             need_rmw,
  input logic             ld_merge,
  input logic             mem_rd_req,
  input logic             mem_wr_en,
  input logic [DW-1:0]    mem_wr_data,
  input logic [CK-1:0]    mem_wr_chk,
  input logic [LANES-1:0] mem_wr_lane_mask
);
  function automatic logic codes_ok(input logic [DW-1:0] d, input logic [CK-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (ecc_encode32(d[LANE_W*i +: LANE_W]) != c[CHK_W*i +: CHK_W]) ok = 1'b0;
    return ok;
  endfunction

  AST_READY_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_req && !mem_wr_en)); // R2
  AST_DIRECT_NEXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !need_rmw) |=> (mem_wr_en && !mem_rd_req)); // R3
  AST_RMW_READS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && need_rmw) |=> (mem_rd_req && !mem_wr_en)); // R4
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R4
  AST_WRITE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> req_ready); // R3
  AST_CODES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> codes_ok(mem_wr_data, mem_wr_chk)); // R1
  AST_MERGE_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ld_merge |=> (mem_wr_en && (&mem_wr_lane_mask))); // R7
endmodule

bind ecc_sram_wr ecc_sram_wr_chk #(.LANES(LANES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_ready        (req_ready),
  .accept           (accept),
  .need_rmw         (need_rmw),
  .ld_merge         (ld_merge),
  .mem_rd_req       (mem_rd_req),
  .mem_wr_en        (mem_wr_en),
  .mem_wr_data      (mem_wr_data),
  .mem_wr_chk       (mem_wr_chk),
  .mem_wr_lane_mask (mem_wr_lane_mask)
);

// File: tb/tb_ecc_sram_wr.sv
module tb_ecc_sram_wr;
  localparam int LN = 8;
  localparam int AW = 16;
  localparam int LAT = 1;
  localparam int DW = LN * 32;
  localparam int BW = DW / 8;
  localparam int CK = LN * 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [BW-1:0] req_be = '0;
  logic mem_rd_req, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_rd_data, mem_wr_data;
  logic [CK-1:0] mem_wr_chk;
  logic [LN-1:0] mem_wr_lane_mask;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  ecc_sram_wr #(.LANES(LN), .ADDR_W(AW), .RD_LAT(LAT)) dut (.*);

  function automatic logic [DW-1:0] stored_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    for (int i = 0; i < LN; i++) w[32*i +: 32] = ((32'(a) + 32'(i)) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    return w;
  endfunction

  // memory model: data valid one cycle after the strobe, junk otherwise
  always @(posedge clk)
    mem_rd_data <= mem_rd_req ? stored_word(mem_rd_addr) : {LN{32'hBAD0_BAD0}};

  function automatic logic [6:0] ref_code(input logic [31:0] d);
    logic cw [1:38];
    logic [6:0] c;
    int k;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if (p == 1 || p == 2 || p == 4 || p == 8 || p == 16 || p == 32) cw[p] = 1'b0;
      else begin cw[p] = d[k]; k++; end
    end
    for (int j = 0; j < 6; j++) begin
      c[j] = 1'b0;
      for (int p = 1; p <= 38; p++) if (p % (2 << j) >= (1 << j)) c[j] = c[j] ^ cw[p];
    end
    c[6] = 1'b0;
    for (int b = 0; b < 32; b++) c[6] = c[6] ^ d[b];
    for (int j = 0; j < 6; j++) c[6] = c[6] ^ c[j];
    return c;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic partial;
    logic [DW-1:0] exp_d, old;
    logic [CK-1:0] exp_c;
    logic [LN-1:0] exp_m;
    int n, rd_cnt, rd_at, wr_at, exp_wr;
    logic rdy1;
    partial = 1'b0;
    old = stored_word(a);
    for (int i = 0; i < LN; i++) begin
      if (be[4*i +: 4] != 4'h0 && be[4*i +: 4] != 4'hF) partial = 1'b1;
      exp_m[i] = |be[4*i +: 4];
    end
    for (int b = 0; b < BW; b++) exp_d[8*b +: 8] = (be[b] || !partial) ? d[8*b +: 8] : old[8*b +: 8];
    if (partial) exp_m = '1;
    for (int i = 0; i < LN; i++) exp_c[7*i +: 7] = ref_code(exp_d[32*i +: 32]);
    exp_wr = partial ? LAT + 2 : 1;

    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1; rd_cnt = 0; rd_at = 0; wr_at = 0; rdy1 = req_ready;
    while (n < 12) begin
      if (mem_rd_req) begin
        rd_cnt++; rd_at = n;
        check(mem_rd_addr == a, "R4 read address", DW'(mem_rd_addr), DW'(a));
      end
      if (mem_wr_en) begin wr_at = n; break; end
      @(negedge clk); n++;
    end
    check(!rdy1, "R2 ready low while busy", DW'(rdy1), 0);
    check(wr_at == exp_wr, partial ? "R5 write cycle" : "R3 write cycle", DW'(wr_at), DW'(exp_wr));
    check(rd_cnt == (partial ? 1 : 0), partial ? "R4 read count" : "R3 no read", DW'(rd_cnt), DW'(partial));
    if (partial) check(rd_at == 1, "R4 read cycle", DW'(rd_at), 1);
    if (wr_at != 0) begin
      for (int i = 0; i < LN; i++)
        if (exp_m[i]) check(mem_wr_data[32*i +: 32] == exp_d[32*i +: 32], partial ? "R6 merged lane" : "R3 lane data",
                            DW'(mem_wr_data[32*i +: 32]), DW'(exp_d[32*i +: 32]));
      check(mem_wr_chk == exp_c, "R1 check codes", DW'(mem_wr_chk), DW'(exp_c));
      check(mem_wr_lane_mask == exp_m, "R7 lane mask", DW'(mem_wr_lane_mask), DW'(exp_m));
      check(mem_wr_addr == a, "R3 write address", DW'(mem_wr_addr), DW'(a));
      @(negedge clk);
      check(req_ready && !mem_wr_en, "R2 ready after write", DW'(req_ready), 1);
    end
  endtask

  function automatic logic [31:0] next_lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !mem_rd_req && !mem_wr_en, "R2 reset state",
          DW'({req_ready, mem_rd_req, mem_wr_en}), DW'(3'b100));

    // walking one through every bit position of every lane (R1)
    for (int b = 0; b < 32; b++) begin
      logic [DW-1:0] d;
      for (int i = 0; i < LN; i++) d[32*i +: 32] = 32'h1 << ((b + 5 * i) % 32);
      run_req(AW'(b), d, '1);
    end

    // every enable nibble on the lowest and highest lane (R4, R6)
    for (int ln = 0; ln < LN; ln += LN - 1) begin
      for (int nib = 0; nib < 16; nib++) begin
        logic [BW-1:0] be;
        logic [DW-1:0] d;
        be = '1;
        be[4*ln +: 4] = 4'(nib);
        for (int i = 0; i < LN; i++) d[32*i +: 32] = 32'hC0DE_0000 + 32'(nib * 16 + i);
        run_req(AW'(100 + nib + ln), d, be);
      end
    end

    // pseudo-random mixes of empty, full and partial lanes (R3..R7)
    for (int t = 0; t < 48; t++) begin
      logic [BW-1:0] be;
      logic [DW-1:0] d;
      for (int i = 0; i < LN; i++) begin
        lcg = next_lcg(lcg);
        d[32*i +: 32] = lcg;
        case (lcg[31:30])
          2'd0:    be[4*i +: 4] = 4'h0;
          2'd1:    be[4*i +: 4] = 4'hF;
          default: be[4*i +: 4] = (t < 16) ? ((lcg[1:0] == 0) ? 4'hF : 4'h0) : lcg[7:4];
        endcase
      end
      run_req(AW'(lcg[15:0]), d, be);
    end

    // no enables at all: direct write with empty mask (R7)
    run_req(AW'(16'hFFFF), '1, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule